// File: doc/BRIEF.md
# CPU-Side Address Redirector for Added SRAM

This block sits between an 8-bit CPU and the mainboard it plugs into. On every CPU bus cycle it decides whether the access is served by the mainboard or by two added 32K×8 SRAM chips. It only touches the six upper address lines (A15..A10) on their way to the mainboard. The lower ten lines, the data bus and the SRAM address pins are wired straight through on the board. The video chip on the mainboard keeps its own view of memory, because the block sees only CPU cycles.

An 8-bit map register is written by the CPU at `$9C00`, an empty I/O page, and marks each of eight regions as mainboard-backed or SRAM-backed. When an access falls into an SRAM-backed region, the mainboard is handed the fixed upper address `100111`, so it makes a harmless dummy access to the empty `$9C00` page and cannot drive the data bus against the SRAM. At the same time, the matching SRAM chip is selected and its output or write enable is driven. Nothing on the mainboard is disabled or overdriven.

There is no data stream here, only bus-cycle decode, so every pin is a plain control or address pin without valid/ready handshaking. The outputs follow the CPU address combinationally. Only the map register is clocked.

Top module: `cpu_map_redirect`

## Requirements
- R1: After reset the map register holds 0, so every address passes to the mainboard unchanged and both SRAM chip selects, the output enable and the write enable are inactive (high).
- R2: A CPU write (phi2 = 1, R/W = 0) to address `$9C00` loads `cpu_d` into the map register at the next rising `clk` edge. Bit 0 controls RAM1-3, bit 1 BLK1, bit 2 BLK2, bit 3 BLK3, bit 4 lower BLK4, bit 5 BLK5, bit 6 BLK6 and bit 7 BLK7. A bit value of 1 means SRAM-backed.
- R3: The regions span these ranges: RAM1-3 `$0400-$0FFF`, BLK1 `$2000-$3FFF`, BLK2 `$4000-$5FFF`, BLK3 `$6000-$7FFF`, lower BLK4 `$8000-$8FFF`, BLK5 `$A000-$BFFF`, BLK6 `$C000-$DFFF` and BLK7 `$E000-$FFFF`.
- R4: For an address in no SRAM-backed region, `host_a_hi` equals CPU A15..A10.
- R5: For an address in an SRAM-backed region, `host_a_hi` is `6'b100111` regardless of the CPU address.
- R6: On an SRAM-backed access, `sram_lo_ce_n` goes low when A15 = 0 and `sram_hi_ce_n` goes low when A15 = 1. Neither goes low on any other access, and they are never low together.
- R7: `sram_oe_n` is low exactly when the access is SRAM-backed and R/W = 1.
- R8: `sram_we_n` is low exactly when the access is SRAM-backed, R/W = 0 and phi2 = 1.
- R9: A write to `$9C00` itself is passed to the mainboard unchanged. A read of `$9C00`, or a write to it while phi2 = 0, leaves the map register unchanged.
- R10: Addresses outside all eight regions (`$0000-$03FF`, `$1000-$1FFF`, `$9000-$9FFF`) are never redirected, even when all map bits are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples map-register writes |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_a | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| phi2 | input | 1 | CPU phase-2 clock level |
| cpu_d | input | 8 | CPU data bus, used for map-register writes |
| host_a_hi | output | 6 | Upper address lines A15..A10 sent to the mainboard |
| sram_lo_ce_n | output | 1 | Chip select, SRAM for A15 = 0, active low |
| sram_hi_ce_n | output | 1 | Chip select, SRAM for A15 = 1, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The address, chip-select and enable outputs respond in the same cycle as the CPU signals that drive them. The bench therefore sets the inputs at a falling `clk` edge and samples one nanosecond later, before any rising edge can intervene. A map-register write becomes visible one rising edge after it is presented. Every write task holds the write through one rising edge and only then moves the address on and probes the effect. This keeps every expected value tied to the exact edge on which it becomes due.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int ADDR_W    = 16;
  localparam int PAGE_W    = 6;   // number of intercepted upper lines
  localparam int N_REGIONS = 8;

  // 1K page bounds of each remappable region (page = address[15:10])
  function automatic logic [PAGE_W-1:0] page_first(input int idx);
    case (idx)
      0: page_first = 6'd1;   // RAM1-3
      1: page_first = 6'd8;   // BLK1
      2: page_first = 6'd16;  // BLK2
      3: page_first = 6'd24;  // BLK3
      4: page_first = 6'd32;  // lower BLK4
      5: page_first = 6'd40;  // BLK5
      6: page_first = 6'd48;  // BLK6
      default: page_first = 6'd56; // BLK7
    endcase
  endfunction

  function automatic logic [PAGE_W-1:0] page_last(input int idx);
    case (idx)
      0: page_last = 6'd3;
      1: page_last = 6'd15;
      2: page_last = 6'd23;
      3: page_last = 6'd31;
      4: page_last = 6'd35;
      5: page_last = 6'd47;
      6: page_last = 6'd55;
      default: page_last = 6'd63;
    endcase
  endfunction

endpackage

// File: rtl/remap_region_dec.sv
module remap_region_dec #(
  parameter int PAGE_W    = remap_pkg::PAGE_W,
  parameter int N_REGIONS = remap_pkg::N_REGIONS
) (
  input  logic [PAGE_W-1:0]    page,
  output logic [N_REGIONS-1:0] region_hit
);

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
    localparam logic [PAGE_W-1:0] FIRST = remap_pkg::page_first(g);
    localparam logic [PAGE_W-1:0] LAST  = remap_pkg::page_last(g);
    assign region_hit[g] = (page >= FIRST) && (page <= LAST);
  end

endmodule

// File: rtl/remap_map_reg.sv
module remap_map_reg #(
  parameter int                ADDR_W    = remap_pkg::ADDR_W,
  parameter int                N_REGIONS = remap_pkg::N_REGIONS,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 16'h9C00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_a,
  input  logic                 cpu_rw,
  input  logic                 phi2,
  input  logic [N_REGIONS-1:0] cpu_d,
  output logic [N_REGIONS-1:0] map_q
);

  logic load;
  assign load = phi2 && !cpu_rw && (cpu_a == REG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)    map_q <= '0;
    else if (load) map_q <= cpu_d;
  end

endmodule

// File: rtl/remap_strobes.sv
module remap_strobes (
  input  logic sram_sel,
  input  logic a_top,
  input  logic cpu_rw,
  input  logic phi2,
  output logic lo_ce_n,
  output logic hi_ce_n,
  output logic oe_n,
  output logic we_n
);

  always_comb begin
    lo_ce_n = !(sram_sel && !a_top);
    hi_ce_n = !(sram_sel &&  a_top);
    oe_n    = !(sram_sel &&  cpu_rw);
    we_n    = !(sram_sel && !cpu_rw && phi2);
  end

endmodule

// File: rtl/cpu_map_redirect.sv
module cpu_map_redirect #(
  parameter int                ADDR_W    = remap_pkg::ADDR_W,
  parameter int                PAGE_W    = remap_pkg::PAGE_W,
  parameter int                N_REGIONS = remap_pkg::N_REGIONS,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 16'h9C00,
  parameter logic [PAGE_W-1:0] DUMMY_HI  = 6'b100111
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_a,
  input  logic                 cpu_rw,
  input  logic                 phi2,
  input  logic [N_REGIONS-1:0] cpu_d,
  output logic [PAGE_W-1:0]    host_a_hi,
  output logic                 sram_lo_ce_n,
  output logic                 sram_hi_ce_n,
  output logic                 sram_oe_n,
  output logic                 sram_we_n
);

  localparam int PAGE_LSB = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0]    page;
  logic [N_REGIONS-1:0] region_hit;
  logic [N_REGIONS-1:0] map_q;
  logic                 sram_sel;

  assign page = cpu_a[ADDR_W-1:PAGE_LSB];

  remap_region_dec #(.PAGE_W(PAGE_W), .N_REGIONS(N_REGIONS)) u_dec (
    .page       (page),
    .region_hit (region_hit)
  );

  remap_map_reg #(.ADDR_W(ADDR_W), .N_REGIONS(N_REGIONS), .REG_ADDR(REG_ADDR)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpu_a  (cpu_a),
    .cpu_rw (cpu_rw),
    .phi2   (phi2),
    .cpu_d  (cpu_d),
    .map_q  (map_q)
  );

  assign sram_sel  = |(region_hit & map_q);
  assign host_a_hi = sram_sel ? DUMMY_HI : page;

  remap_strobes u_stb (
    .sram_sel (sram_sel),
    .a_top    (cpu_a[ADDR_W-1]),
    .cpu_rw   (cpu_rw),
    .phi2     (phi2),
    .lo_ce_n  (sram_lo_ce_n),
    .hi_ce_n  (sram_hi_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n)
  );

endmodule

// File: rtl/cpu_map_redirect_chk.sv
module cpu_map_redirect_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                PAGE_W    = 6,
  parameter int                N_REGIONS = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 16'h9C00,
  parameter logic [PAGE_W-1:0] DUMMY_HI  = 6'b100111
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    cpu_a,
  input logic                 cpu_rw,
  input logic                 phi2,
  input logic [N_REGIONS-1:0] cpu_d,
  input logic [PAGE_W-1:0]    host_a_hi,
  input logic                 sram_lo_ce_n,
  input logic                 sram_hi_ce_n,
  input logic                 sram_oe_n,
  input logic                 sram_we_n,
  input logic [N_REGIONS-1:0] map_q
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !cpu_rw && cpu_a == REG_ADDR) |=> map_q == $past(cpu_d));

  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_lo_ce_n && sram_hi_ce_n) |-> host_a_hi == cpu_a[ADDR_W-1:ADDR_W-PAGE_W]);

  p_dummy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_lo_ce_n || !sram_hi_ce_n) |-> host_a_hi == DUMMY_HI);

  p_one_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!sram_lo_ce_n, !sram_hi_ce_n}) <= 1);

  p_lo_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_lo_ce_n |-> !cpu_a[ADDR_W-1]);

  p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (cpu_rw && !sram_we_n == 1'b0));

  p_we_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (phi2 && !cpu_rw && (!sram_lo_ce_n || !sram_hi_ce_n)));

  p_reg_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_a == REG_ADDR) |-> (host_a_hi == DUMMY_HI && sram_lo_ce_n && sram_hi_ce_n));

endmodule

bind cpu_map_redirect cpu_map_redirect_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .N_REGIONS(N_REGIONS),
  .REG_ADDR(REG_ADDR), .DUMMY_HI(DUMMY_HI)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_a        (cpu_a),
  .cpu_rw       (cpu_rw),
  .phi2         (phi2),
  .cpu_d        (cpu_d),
  .host_a_hi    (host_a_hi),
  .sram_lo_ce_n (sram_lo_ce_n),
  .sram_hi_ce_n (sram_hi_ce_n),
  .sram_oe_n    (sram_oe_n),
  .sram_we_n    (sram_we_n),
  .map_q        (map_q)
);

// File: tb/cpu_map_redirect_bench.sv
`timescale 1ns/1ps
module cpu_map_redirect_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_a = 16'h0000;
  logic        cpu_rw = 1'b1;
  logic        phi2 = 1'b0;
  logic [7:0]  cpu_d = 8'h00;
  logic [5:0]  host_a_hi;
  logic        sram_lo_ce_n, sram_hi_ce_n, sram_oe_n, sram_we_n;

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [7:0]  map_m    = 8'h00;   // bench copy of the map register

  always #2.5 clk = ~clk;          // 200 MHz

  cpu_map_redirect u_cpu_map_redirect (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_a        (cpu_a),
    .cpu_rw       (cpu_rw),
    .phi2         (phi2),
    .cpu_d        (cpu_d),
    .host_a_hi    (host_a_hi),
    .sram_lo_ce_n (sram_lo_ce_n),
    .sram_hi_ce_n (sram_hi_ce_n),
    .sram_oe_n    (sram_oe_n),
    .sram_we_n    (sram_we_n)
  );

  // region index from the address ranges in R3, -1 outside all regions
  function automatic int region_of(input logic [15:0] a);
    if (a >= 16'h0400 && a <= 16'h0FFF) return 0;
    if (a >= 16'h2000 && a <= 16'h3FFF) return 1;
    if (a >= 16'h4000 && a <= 16'h5FFF) return 2;
    if (a >= 16'h6000 && a <= 16'h7FFF) return 3;
    if (a >= 16'h8000 && a <= 16'h8FFF) return 4;
    if (a >= 16'hA000 && a <= 16'hBFFF) return 5;
    if (a >= 16'hC000 && a <= 16'hDFFF) return 6;
    if (a >= 16'hE000)                  return 7;
    return -1;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (hi,lo_ce,hi_ce,oe,we)", req, act, exp);
    end
  endtask

  // drive one CPU cycle at a falling edge and compare all outputs
  task automatic probe(input string req, input logic [15:0] a, input logic rw, input logic p2);
    int  r;
    logic hit;
    logic [9:0] exp;
    @(negedge clk);
    cpu_a = a; cpu_rw = rw; phi2 = p2; cpu_d = 8'h00;
    #1;
    r   = region_of(a);
    hit = (r >= 0) && map_m[r];
    exp = {hit ? 6'b100111 : a[15:10], !(hit && !a[15]), !(hit && a[15]),
           !(hit && rw), !(hit && !rw && p2)};
    check(req, {host_a_hi, sram_lo_ce_n, sram_hi_ce_n, sram_oe_n, sram_we_n}, exp);
  endtask

  // write the map register; the write itself must pass through (R9)
  task automatic write_map(input logic [7:0] d);
    @(negedge clk);
    cpu_a = 16'h9C00; cpu_rw = 1'b0; phi2 = 1'b1; cpu_d = d;
    #1;
    check("R9 write passes", {host_a_hi, sram_lo_ce_n, sram_hi_ce_n, sram_oe_n, sram_we_n},
          {6'b100111, 4'b1111});
    @(negedge clk);
    phi2 = 1'b0; cpu_rw = 1'b1;
    map_m = d;
  endtask

  task automatic t_reset();
    probe("R1 reset BLK1", 16'h2000, 1'b1, 1'b1);
    probe("R1 reset BLK7 write", 16'hE010, 1'b0, 1'b1);
  endtask

  task automatic t_single_bits();
    for (int i = 0; i < 8; i++) begin
      write_map(8'h01 << i);
      probe("R2 bit selects region", 16'h2000 * 16'(i == 0 ? 0 : i) + (i == 0 ? 16'h0400 : 16'h0000), 1'b1, 1'b1);
      probe("R4 other regions pass", 16'h0800 + 16'h2000 * 16'((i + 1) % 8), 1'b1, 1'b1);
    end
  endtask

  task automatic t_all_edges();
    write_map(8'hFF);
    probe("R3 RAM1-3 low edge",   16'h0400, 1'b1, 1'b1);
    probe("R3 RAM1-3 high edge",  16'h0FFF, 1'b1, 1'b1);
    probe("R3 BLK1 high edge",    16'h3FFF, 1'b1, 1'b1);
    probe("R3 BLK3 high edge",    16'h7FFF, 1'b1, 1'b1);
    probe("R3 BLK4 low edge",     16'h8000, 1'b1, 1'b1);
    probe("R3 BLK4 half edge",    16'h8FFF, 1'b1, 1'b1);
    probe("R5 BLK5 redirected",   16'hA5A5, 1'b1, 1'b1);
    probe("R6 BLK7 top",          16'hFFFF, 1'b1, 1'b1);
    probe("R10 page zero",        16'h03FF, 1'b1, 1'b1);
    probe("R10 gap 1000",         16'h1000, 1'b1, 1'b1);
    probe("R10 gap 1FFF",         16'h1FFF, 1'b1, 1'b1);
    probe("R10 io 9000",          16'h9000, 1'b1, 1'b1);
    probe("R10 io 9FFF",          16'h9FFF, 1'b1, 1'b1);
  endtask

  task automatic t_strobes();
    write_map(8'hFF);
    probe("R8 write phi2 high hi chip", 16'hC123, 1'b0, 1'b1);
    probe("R8 write phi2 low",          16'hC123, 1'b0, 1'b0);
    probe("R8 write lo chip",           16'h4321, 1'b0, 1'b1);
    probe("R7 read lo chip",            16'h6000, 1'b1, 1'b0);
    probe("R7 read hi chip",            16'hB000, 1'b1, 1'b1);
  endtask

  task automatic t_ignored_writes();
    write_map(8'h00);
    // write with phi2 low must not load
    @(negedge clk);
    cpu_a = 16'h9C00; cpu_rw = 1'b0; phi2 = 1'b0; cpu_d = 8'hFF;
    @(negedge clk);
    probe("R9 phi2-low write ignored", 16'h2000, 1'b1, 1'b1);
    // read of the register address must not load
    @(negedge clk);
    cpu_a = 16'h9C00; cpu_rw = 1'b1; phi2 = 1'b1; cpu_d = 8'hFF;
    @(negedge clk);
    probe("R9 read ignored", 16'hE000, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_bits();
    t_all_edges();
    t_strobes();
    t_ignored_writes();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule